// File: doc/BRIEF.md
# Four-Way Cache Tag and Replacement Controller

This block holds the tag, valid and modified state of a 4-way set-associative cache with 32-byte lines and 128 sets, plus the recency ordering that chooses which way to replace. It serves 32-bit byte addresses. A lookup compares the tags of all four ways of the selected set at once. One cycle later it reports hit or miss and a way number. On a hit, that way is the matching way. On a miss, it is the way chosen for replacement.

Each set stores an explicit list of its four ways, ordered from most to least recently used. A hit or a refill moves the touched way to the head of the list. On a miss, any invalid way is used first. Otherwise the way at the tail of the list is replaced. If the victim holds modified data, the block first asks the next level to take that line back. It waits for the acknowledge before it asks for the new line. The line data arrays and the next-level memory lie outside the block. The next level is reached through two request/acknowledge handshakes: one for write-back and one for refill.

Top module: `cache_tag_ctrl`

## Requirements
- R1: Address bits 4:0 are the byte offset, bits 11:5 the set index and bits 31:12 the tag. Addresses 64 and 12352 therefore fall in one set, and 12384 falls in a different set.
- R2: A request with req_valid high while req_ready is high gives resp_valid high on the next cycle. On a hit, resp_hit is 1 and resp_way is the way that holds the tag.
- R3: After reset every line is invalid. Every set is ordered way 0, 1, 2, 3 from most to least recent. req_ready is 1, and wb_req and fill_req are 0.
- R4: On a hit, the matching way moves to the most-recent position. The ways that were ahead of it each shift back by one position.
- R5: On a miss, resp_hit is 0 and resp_way names the victim. The victim is the lowest-numbered invalid way of the set. If all four ways are valid, it is the least-recent way.
- R6: A write hit marks the matching way modified in the same cycle as its recency update.
- R7: A modified victim raises wb_req, with wb_addr equal to {victim tag, set index, 5'b0}. Both hold until wb_ack. A clean or invalid victim produces no write-back.
- R8: fill_req rises only together with a miss response that needs no write-back, or on the cycle after wb_ack. It holds until fill_done, with fill_addr equal to {request tag, set index, 5'b0}.
- R9: On fill_done, the victim way takes the new tag and becomes valid. It is clean after a read miss and modified after a write miss. It moves to the most-recent position, and req_ready returns to 1.
- R10: While a miss is being served, req_ready is 0. Requests presented then produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a store |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Block idle and accepting lookups |
| resp_valid | output | 1 | Lookup result valid (one cycle) |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 2 | Hit way, or victim way on a miss |
| wb_req | output | 1 | Write-back request for a modified victim |
| wb_addr | output | 32 | Line address being written back |
| wb_ack | input | 1 | Next level has taken the write-back |
| fill_req | output | 1 | Refill request |
| fill_addr | output | 32 | Line address to refill |
| fill_done | input | 1 | Refill complete |

## Verification
The bench uses the default parameters: four ways, 128 sets and 32-byte lines. All 128 sets are swept, so every index value is exercised. In each set, the sweep fills the empty ways, hits them in a new order and dirties one way with a store. It then forces an eviction, which checks the invalid-first choice, the least-recent choice and the write-back path against an arithmetic model of the recency lists. Directed cases follow: the 4096-byte aliasing examples, write misses evicted later, and requests presented while a miss is outstanding.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } ctc_state_e;
endpackage

// File: rtl/ctc_way_match.sv
module ctc_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ctc_victim.sv
module ctc_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  order,
    output logic [WAY_W-1:0]            victim
);
    always_comb begin
        victim = order[WAYS-1];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) victim = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ctc_mtf.sv
module ctc_mtf #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0]  order_in,
    input  logic [WAY_W-1:0]            way,
    output logic [WAYS-1:0][WAY_W-1:0]  order_out
);
    logic [WAY_W-1:0] pos;

    always_comb begin
        pos = WAY_W'(WAYS - 1);
        for (int p = WAYS - 1; p >= 0; p--) begin
            if (order_in[p] == way) pos = WAY_W'(p);
        end
    end

    assign order_out[0] = way;
    for (genvar p = 1; p < WAYS; p++) begin : g_shift
        assign order_out[p] = (WAY_W'(p) <= pos) ? order_in[p-1] : order_in[p];
    end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 7,
    parameter int WAYS   = 4,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
    localparam int SETS  = 1 << IDX_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_done
);
    typedef struct packed {
        ctc_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [WAY_W-1:0] way;
        logic [TAG_W-1:0] tag;
        logic             wr;
        logic             rsp_v;
        logic             rsp_hit;
        logic [WAY_W-1:0] rsp_way;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]            tag_q   [SETS][WAYS];
    logic [WAYS-1:0]             val_q   [SETS];
    logic [WAYS-1:0]             dirty_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  ord_q   [SETS];

    logic [IDX_W-1:0]            req_idx;
    logic [TAG_W-1:0]            req_tag;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            vic_way;
    logic [IDX_W-1:0]            mtf_idx;
    logic [WAY_W-1:0]            mtf_way;
    logic [WAYS-1:0][WAY_W-1:0]  mtf_out;
    logic                        upd_ord, upd_dirty, upd_fill;

    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_idx][w];
    end

    ctc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid   (val_q[req_idx]),
        .tags    (set_tags),
        .tag     (req_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    ctc_victim #(.WAYS(WAYS)) u_victim (
        .valid  (val_q[req_idx]),
        .order  (ord_q[req_idx]),
        .victim (vic_way)
    );

    assign mtf_idx = (ctl_q.st == ST_IDLE) ? req_idx : ctl_q.idx;
    assign mtf_way = (ctl_q.st == ST_IDLE) ? hit_way : ctl_q.way;

    ctc_mtf #(.WAYS(WAYS)) u_mtf (
        .order_in  (ord_q[mtf_idx]),
        .way       (mtf_way),
        .order_out (mtf_out)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        upd_ord     = 1'b0;
        upd_dirty   = 1'b0;
        upd_fill    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.rsp_v   = 1'b1;
                    ctl_d.rsp_hit = hit;
                    if (hit) begin
                        ctl_d.rsp_way = hit_way;
                        upd_ord       = 1'b1;
                        upd_dirty     = req_write;
                    end else begin
                        ctl_d.rsp_way = vic_way;
                        ctl_d.idx     = req_idx;
                        ctl_d.way     = vic_way;
                        ctl_d.tag     = req_tag;
                        ctl_d.wr      = req_write;
                        ctl_d.st      = (val_q[req_idx][vic_way] && dirty_q[req_idx][vic_way])
                                        ? ST_WB : ST_FILL;
                    end
                end
            end
            ST_WB: begin
                if (wb_ack) ctl_d.st = ST_FILL;
            end
            ST_FILL: begin
                if (fill_done) begin
                    upd_fill = 1'b1;
                    upd_ord  = 1'b1;
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                val_q[s]   <= '0;
                dirty_q[s] <= '0;
                for (int p = 0; p < WAYS; p++) ord_q[s][p] <= WAY_W'(p);
            end
        end else begin
            ctl_q <= ctl_d;
            if (upd_ord)   ord_q[mtf_idx] <= mtf_out;
            if (upd_dirty) dirty_q[req_idx][hit_way] <= 1'b1;
            if (upd_fill) begin
                val_q[ctl_q.idx][ctl_q.way]   <= 1'b1;
                dirty_q[ctl_q.idx][ctl_q.way] <= ctl_q.wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (upd_fill) tag_q[ctl_q.idx][ctl_q.way] <= ctl_q.tag;
    end

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign resp_valid = ctl_q.rsp_v;
    assign resp_hit   = ctl_q.rsp_hit;
    assign resp_way   = ctl_q.rsp_way;
    assign wb_req     = (ctl_q.st == ST_WB);
    assign wb_addr    = {tag_q[ctl_q.idx][ctl_q.way], ctl_q.idx, {OFF_W{1'b0}}};
    assign fill_req   = (ctl_q.st == ST_FILL);
    assign fill_addr  = {ctl_q.tag, ctl_q.idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_done
);
    // R7 / R8: write-back and refill never overlap
    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && fill_req));

    // R7: write-back request and address hold until acknowledged
    a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));

    // R8: refill request and address hold until done
    a_r8_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_done) |=> (fill_req && $stable(fill_addr)));

    // R8: refill starts with a miss response or right after a write-back ack
    a_r8_fill_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> ((resp_valid && !resp_hit) || $past(wb_req && wb_ack)));

    // R10: not ready while a miss is outstanding
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req || fill_req) |-> !req_ready);

    // R2: a hit leaves the block ready
    a_r2_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit) |-> req_ready);
endmodule

bind cache_tag_ctrl ctc_checker #(.ADDR_W(ADDR_W)) u_ctc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .wb_req     (wb_req),
    .wb_addr    (wb_addr),
    .wb_ack     (wb_ack),
    .fill_req   (fill_req),
    .fill_addr  (fill_addr),
    .fill_done  (fill_done)
);

// File: tb/sim_cache_tag_ctrl.sv
module sim_cache_tag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 128;
    localparam int NWAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, resp_hit;
    logic [1:0]  resp_way;
    logic        wb_req, fill_req;
    logic [31:0] wb_addr, fill_addr;
    logic        wb_ack = 1'b0;
    logic        fill_done = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    bit        m_val   [NSETS][NWAYS];
    bit        m_dirty [NSETS][NWAYS];
    bit [19:0] m_tag   [NSETS][NWAYS];
    int        m_ord   [NSETS][NWAYS];

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_tag_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_done(fill_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_front(input int s, input int w);
        int p;
        p = NWAYS - 1;
        for (int i = 0; i < NWAYS; i++) if (m_ord[s][i] == w) begin p = i; break; end
        for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
        m_ord[s][0] = w;
    endtask

    task automatic access(input logic [31:0] a, input bit w, input string req);
        int s, exp_way, v;
        bit exp_hit, exp_wb;
        logic [19:0] tg;
        s = int'(a[11:5]);
        tg = a[31:12];
        exp_hit = 0; exp_way = 0;
        for (int i = 0; i < NWAYS; i++)
            if (m_val[s][i] && m_tag[s][i] == tg && !exp_hit) begin exp_hit = 1; exp_way = i; end
        if (!exp_hit) begin
            v = -1;
            for (int i = 0; i < NWAYS; i++) if (!m_val[s][i] && v < 0) v = i;
            if (v < 0) v = m_ord[s][NWAYS-1];
            exp_way = v;
        end
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        chk(resp_valid == 1, req, "R2 resp_valid", 64'(resp_valid), 64'd1);
        chk(resp_hit == exp_hit, req, "R2/R5 resp_hit", 64'(resp_hit), 64'(exp_hit));
        chk(int'(resp_way) == exp_way, req, "R4/R5 resp_way", 64'(resp_way), 64'(exp_way));
        if (exp_hit) begin
            model_front(s, exp_way);
            if (w) m_dirty[s][exp_way] = 1;
            chk(req_ready == 1 && fill_req == 0, req, "R2 ready after hit",
                64'({req_ready, fill_req}), 64'b10);
        end else begin
            exp_wb = m_val[s][exp_way] && m_dirty[s][exp_way];
            chk(req_ready == 0, req, "R10 busy on miss", 64'(req_ready), 64'd0);
            if (exp_wb) begin
                chk(wb_req == 1 && fill_req == 0, req, "R7/R8 wb first",
                    64'({wb_req, fill_req}), 64'b10);
                chk(wb_addr == {m_tag[s][exp_way], a[11:5], 5'b0}, req, "R7 wb_addr",
                    64'(wb_addr), 64'({m_tag[s][exp_way], a[11:5], 5'b0}));
                req_valid = 1; req_addr = a ^ 32'h0000_1000;
                @(negedge clk);
                req_valid = 0;
                @(negedge clk);
                chk(resp_valid == 0 && wb_req == 1 && fill_req == 0, req,
                    "R10/R8 ignored while waiting", 64'({resp_valid, wb_req, fill_req}), 64'b010);
                wb_ack = 1;
                @(negedge clk);
                wb_ack = 0;
            end else begin
                chk(wb_req == 0, req, "R7 no wb for clean victim", 64'(wb_req), 64'd0);
            end
            chk(fill_req == 1 && wb_req == 0, req, "R8 fill_req",
                64'({fill_req, wb_req}), 64'b10);
            chk(fill_addr == {tg, a[11:5], 5'b0}, req, "R8 fill_addr",
                64'(fill_addr), 64'({tg, a[11:5], 5'b0}));
            fill_done = 1;
            @(negedge clk);
            fill_done = 0;
            chk(req_ready == 1 && fill_req == 0, req, "R9 ready after fill",
                64'({req_ready, fill_req}), 64'b10);
            m_val[s][exp_way] = 1;
            m_dirty[s][exp_way] = w;
            m_tag[s][exp_way] = tg;
            model_front(s, exp_way);
        end
    endtask

    function automatic logic [31:0] mk(input int tg, input int s, input int off);
        return {20'(tg), 7'(s), 5'(off)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) begin
                m_val[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = '0; m_ord[s][w] = w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && wb_req == 0 && fill_req == 0 && resp_valid == 0, "R3",
            "reset outputs", 64'({req_ready, wb_req, fill_req, resp_valid}), 64'b1000);

        // sweep every set: invalid-first fills, hits, store hit, LRU eviction
        for (int s = 0; s < NSETS; s++) begin
            for (int t = 1; t <= 4; t++) access(mk(t + s, s, s), 0, "R3/R5 fill empty");
            access(mk(3 + s, s, 1), 0, "R4 hit");
            access(mk(1 + s, s, 2), 0, "R4 hit");
            access(mk(4 + s, s, 3), 0, "R4 hit");
            access(mk(((s % 4) + 1) + s, s, 4), 1, "R6 store hit");
            access(mk(100 + s, s, 0), 0, "R5/R7 evict LRU");
            access(mk(200 + s, s, 0), 0, "R5/R7 evict LRU");
            access(mk(300 + s, s, 0), 0, "R5/R7 evict LRU");
        end

        // aliasing: 64 and 12352 share set 2, 12384 lies in set 3
        access(32'd64, 0, "R1 alias");
        access(32'd12352, 0, "R1 alias");
        access(32'd64, 0, "R1 alias hit");
        access(32'd12352, 1, "R1 alias hit");
        access(32'd12384, 0, "R1 other set");
        access(32'd64, 0, "R1 alias still hit");
        access(32'd12384, 0, "R1 other set hit");

        // write miss leaves the line dirty, later eviction writes it back
        access(mk(777, 9, 7), 1, "R9 write miss");
        for (int t = 0; t < 4; t++) access(mk(900 + t, 9, 0), 0, "R9 evict dirty fill");
        access(mk(777, 9, 0), 0, "R9 refetch");
        for (int t = 0; t < 4; t++) access(mk(950 + t, 9, 0), 1, "R7 write evict");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule